// File: doc/BRIEF.md
# Rate-Limited Remote Timer Scheduler

This block sits between the software timer list and a remote service engine that owns a hardware timer. Whenever software presents a new earliest deadline on the timebase, the block decides whether to send a timer-start command to the engine. The command carries a delay in whole microseconds, obtained by rounding the remaining timebase ticks up. Delays no longer than a fixed minimum are raised to that minimum.

Only one start command is outstanding at a time. A deadline that arrives while a command is in flight is kept only if it is earlier than the one already stored, and it is sent in the cycle after the command completes. A running timer is replaced only if the new deadline is earlier, the running one has not yet passed, and more than the minimum interval of it remains. Each expiry event allows a bounded number of start commands. If a running timer overshoots its expected expiry by a grace period and no expiry event arrives, the block raises a permanent failure flag so that the system falls back to polling.

Top module: `remote_timer_sched`

## Requirements
- R1: After reset, cmd_req, cmd_ticks and timer_failed are all zero.
- R2: When idle and not running, a new target more than MIN_US*TPU ticks after `now` issues cmd_req one cycle later, with cmd_ticks = ceil((target-now)/TPU).
- R3: If the target is at most MIN_US*TPU ticks ahead of `now`, or is not ahead of it at all, cmd_ticks = MIN_US. Every command carries at least MIN_US.
- R4: A target equal to the stored target has no effect.
- R5: At most one command is outstanding. While one is in flight, a target earlier than the stored one is recorded and a later one is dropped. The recorded target is evaluated in the cycle after cmd_done and issued one cycle after that.
- R6: While a timer runs, a new target is dropped if it is not earlier than the expected expiry, if `now` has reached that expiry, or if at most MIN_US*TPU ticks of it remain.
- R7: Between two expiry events at most MAX_UPD+1 commands are issued; expiry_evt resets the count.
- R8: A cmd_done with cmd_ok=1 sets the expected expiry to now + cmd_ticks*TPU and marks the timer running. With cmd_ok=0, neither changes.
- R9: If the timer is running and `now` exceeds the expected expiry plus GRACE_US*TPU, timer_failed rises on the next cycle and stays high. After that no command is issued.
- R10: An expiry_evt in the same cycle as a new target is applied first: the timer counts as not running and the command count is zero for that target.
- R11: A new earlier target arriving in the same cycle as the deferred send after cmd_done replaces the recorded target in that send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_valid | input | 1 | New earliest deadline present |
| tgt_value | input | TW | Deadline in timebase ticks |
| now | input | TW | Current timebase value |
| cmd_done | input | 1 | Outstanding start command completed |
| cmd_ok | input | 1 | Completion status, 1 = success |
| expiry_evt | input | 1 | Remote timer fired |
| cmd_req | output | 1 | One-cycle timer-start command |
| cmd_ticks | output | TW | Microsecond delay of the last command |
| timer_failed | output | 1 | Timer declared stuck; use polling |

## Verification
Two pairs of events can fall in the same cycle. In the first, an expiry event coincides with a new target while the replacement count is exhausted. The target must still go out, because the count and the running state are cleared first. In the second, a fresh earlier target lands exactly in the deferred-send cycle after a completion, and the issued delay must reflect the fresh target rather than the recorded one. The bench drives both coincidences on purpose and judges them by the delay value and the timing of cmd_req, which a cycle-by-cycle reference model predicts on every clock.

// File: rtl/remote_timer_sched.sv
module remote_timer_sched #(
  parameter int TW       = 40,
  parameter int TPU      = 12,
  parameter int MIN_US   = 500,
  parameter int GRACE_US = 10000,
  parameter int MAX_UPD  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tgt_valid,
  input  logic [TW-1:0] tgt_value,
  input  logic [TW-1:0] now,
  input  logic          cmd_done,
  input  logic          cmd_ok,
  input  logic          expiry_evt,
  output logic          cmd_req,
  output logic [TW-1:0] cmd_ticks,
  output logic          timer_failed
);

  localparam int CW   = $clog2(MAX_UPD + 2);
  localparam int LOGT = (TPU > 1) ? $clog2(TPU) : 0;
  localparam int SH   = TW + 1 + LOGT;
  localparam int PW   = SH + TW + 2;
  localparam logic [63:0]   RECIP    = ((64'd1 << SH) + 64'(TPU) - 64'd1) / 64'(TPU);
  localparam logic [TW-1:0] MIN_TB   = TW'(MIN_US * TPU);
  localparam logic [TW:0]   GRACE_TB = (TW+1)'(GRACE_US * TPU);

  logic [TW-1:0] target_q, stamp_q;
  logic          inflight_q, pending_q, running_q;
  logic [CW-1:0] upd_q;

  logic          run_e, stuck, tgt_new, tgt_early, drain, direct, blocked, send, done_ok;
  logic [CW-1:0] cnt_e;
  logic [TW-1:0] aim, left, diff, quot, ticks_nx, stamp_nx;
  logic [TW:0]   numer;
  logic [PW-1:0] prod;

  assign run_e     = running_q & ~expiry_evt;
  assign cnt_e     = expiry_evt ? '0 : upd_q;
  assign stuck     = run_e & ~timer_failed & ({1'b0, now} > ({1'b0, stamp_q} + GRACE_TB));
  assign tgt_new   = tgt_valid & ~timer_failed & (tgt_value != target_q);
  assign tgt_early = tgt_new & (tgt_value < target_q);
  assign drain     = pending_q & ~inflight_q & ~timer_failed;
  assign direct    = tgt_new & ~inflight_q & ~pending_q;
  assign aim       = (direct | tgt_early) ? tgt_value : target_q;
  assign left      = stamp_q - now;
  assign blocked   = run_e & ((aim >= stamp_q) | (now >= stamp_q) | (left <= MIN_TB));
  assign send      = (direct | drain) & ~stuck & ~blocked & (cnt_e <= CW'(MAX_UPD));
  assign done_ok   = cmd_done & inflight_q & cmd_ok & ~stuck & ~timer_failed;

  assign diff     = (aim > now) ? (aim - now) : '0;
  assign numer    = {1'b0, diff} + (TW+1)'(TPU - 1);
  assign prod     = PW'(numer) * PW'(RECIP);
  assign quot     = TW'(prod >> SH);
  assign ticks_nx = (diff > MIN_TB) ? quot : TW'(MIN_US);
  assign stamp_nx = now + cmd_ticks * TW'(TPU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q     <= '0;
      stamp_q      <= '1;
      inflight_q   <= 1'b0;
      pending_q    <= 1'b0;
      running_q    <= 1'b0;
      upd_q        <= '0;
      cmd_req      <= 1'b0;
      cmd_ticks    <= '0;
      timer_failed <= 1'b0;
    end else begin
      cmd_req <= send;
      upd_q   <= send ? cnt_e + CW'(1) : cnt_e;
      if (send) cmd_ticks <= ticks_nx;
      if (direct | tgt_early) target_q <= tgt_value;

      if (stuck | drain)            pending_q <= 1'b0;
      else if (tgt_early & ~direct) pending_q <= 1'b1;

      if (send)          inflight_q <= 1'b1;
      else if (cmd_done) inflight_q <= 1'b0;

      if (stuck | timer_failed) running_q <= 1'b0;
      else if (done_ok)         running_q <= 1'b1;
      else                      running_q <= run_e;

      if (done_ok) stamp_q <= stamp_nx;
      if (stuck)   timer_failed <= 1'b1;
    end
  end

endmodule

// File: rtl/remote_timer_sched_chk.sv
module remote_timer_sched_chk #(
  parameter int TW      = 40,
  parameter int MIN_US  = 500,
  parameter int MAX_UPD = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          expiry_evt,
  input logic          cmd_req,
  input logic [TW-1:0] cmd_ticks,
  input logic          timer_failed
);

  logic       exp_d;
  logic [3:0] sent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_d  <= 1'b0;
      sent_q <= '0;
    end else begin
      exp_d <= expiry_evt;
      if (exp_d)                     sent_q <= {3'b0, cmd_req};
      else if (cmd_req && sent_q != 4'hF) sent_q <= sent_q + 4'd1;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) cmd_req |=> !cmd_req); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) timer_failed |=> timer_failed); // R9
  AST_QUIET_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n) timer_failed |-> !cmd_req); // R9
  AST_TICKS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) cmd_req |-> cmd_ticks >= TW'(MIN_US)); // R3
  AST_TICKS_HELD: assert property (@(posedge clk) disable iff (!rst_n) !cmd_req |-> $stable(cmd_ticks)); // R2
  AST_RATE_CAP: assert property (@(posedge clk) disable iff (!rst_n) (cmd_req && !exp_d) |-> sent_q <= 4'(MAX_UPD)); // R7

endmodule

bind remote_timer_sched remote_timer_sched_chk #(.TW(TW), .MIN_US(MIN_US), .MAX_UPD(MAX_UPD)) u_chk (
  .clk(clk), .rst_n(rst_n), .expiry_evt(expiry_evt), .cmd_req(cmd_req),
  .cmd_ticks(cmd_ticks), .timer_failed(timer_failed)
);

// File: tb/remote_timer_sched_test.sv
module remote_timer_sched_test;
  localparam int TW = 40, TPU = 12, MIN_US = 500, GRACE_US = 10000, MAX_UPD = 2;
  localparam longint unsigned MIN_TB = MIN_US * TPU, GRACE_TB = GRACE_US * TPU;

  logic clk = 0, rst_n = 0;
  logic tv = 0, done = 0, ok = 0, expv = 0;
  logic [TW-1:0] tval = '0, now = '0;
  logic cmd_req, timer_failed;
  logic [TW-1:0] cmd_ticks;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  remote_timer_sched #(.TW(TW), .TPU(TPU), .MIN_US(MIN_US), .GRACE_US(GRACE_US), .MAX_UPD(MAX_UPD)) uut (
    .clk(clk), .rst_n(rst_n), .tgt_valid(tv), .tgt_value(tval), .now(now),
    .cmd_done(done), .cmd_ok(ok), .expiry_evt(expv),
    .cmd_req(cmd_req), .cmd_ticks(cmd_ticks), .timer_failed(timer_failed));

  // behavioural reference model
  longint unsigned m_target, m_stamp, m_ticks, m_aim, m_t, m_n, m_d;
  bit m_req, m_infl, m_pend, m_run, m_fail, m_oi, m_op, m_stk;
  int m_cnt;

  task automatic m_try(input longint unsigned a);
    if (m_run && (a >= m_stamp || m_n >= m_stamp || m_stamp - m_n <= MIN_TB)) return;
    if (m_cnt > MAX_UPD) return;
    m_cnt++;
    m_d = (a > m_n) ? a - m_n : 0;
    m_ticks = (m_d > MIN_TB) ? (m_d + TPU - 1) / TPU : MIN_US;
    m_req = 1; m_infl = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_target = 0; m_stamp = (64'd1 << TW) - 1; m_ticks = 0; m_req = 0;
      m_infl = 0; m_pend = 0; m_run = 0; m_fail = 0; m_cnt = 0;
    end else begin
      m_oi = m_infl; m_op = m_pend; m_req = 0; m_t = tval; m_n = now;
      if (expv) begin m_run = 0; m_cnt = 0; end
      m_stk = !m_fail && m_run && (m_n > m_stamp + GRACE_TB);
      if (m_stk) begin m_fail = 1; m_run = 0; m_pend = 0; end
      if (done && m_oi) begin
        m_infl = 0;
        if (ok && !m_fail) begin m_stamp = m_n + m_ticks * TPU; m_run = 1; end
      end
      if (!m_fail) begin
        if (m_op && !m_oi) begin
          m_aim = m_target;
          if (tv && m_t < m_target) begin m_target = m_t; m_aim = m_t; end
          m_pend = 0;
          m_try(m_aim);
        end else if (tv && m_t != m_target) begin
          if (m_oi || m_op) begin
            if (m_t < m_target) begin m_target = m_t; m_pend = 1; end
          end else begin
            m_target = m_t;
            m_try(m_t);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (cmd_req !== m_req || cmd_ticks !== TW'(m_ticks) || timer_failed !== m_fail) begin
        fails++;
        $display("FAIL %s model: actual req=%0b ticks=%0d failed=%0b expected req=%0b ticks=%0d failed=%0b",
                 phase, cmd_req, cmd_ticks, timer_failed, m_req, m_ticks, m_fail);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL %s watchdog: actual cycles=%0d expected below 20000", phase, cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tgt(input longint unsigned v);
    @(negedge clk) begin tv = 1; tval = TW'(v); end
    @(negedge clk) tv = 0;
  endtask

  task automatic fin(input bit good);
    @(negedge clk) begin done = 1; ok = good; end
    @(negedge clk) begin done = 0; ok = 0; end
  endtask

  task automatic expire();
    @(negedge clk) expv = 1;
    @(negedge clk) expv = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req", cmd_req, 0); chk("R1 ticks", cmd_ticks, 0); chk("R1 failed", timer_failed, 0);

    phase = "R3"; now = 1000;
    tgt(7000);  chk("R3 req at min", cmd_req, 1); chk("R3 ticks at min", cmd_ticks, 500);
    fin(0);
    tgt(500);   chk("R3 req past", cmd_req, 1); chk("R3 ticks past", cmd_ticks, 500);
    fin(0);
    phase = "R4";
    tgt(500);   chk("R4 equal target", cmd_req, 0);
    expire();

    phase = "R2";
    tgt(9401);  chk("R2 req", cmd_req, 1); chk("R2 ticks rounded up", cmd_ticks, 701);
    fin(1);
    phase = "R6";
    tgt(20000); chk("R6 not earlier", cmd_req, 0);
    tgt(9000);  chk("R6 replace req", cmd_req, 1); chk("R6 replace ticks", cmd_ticks, 667);
    fin(1);
    now = 3100;
    tgt(8000);  chk("R6 little left", cmd_req, 0);
    now = 9500;
    tgt(7000);  chk("R6 expiry passed", cmd_req, 0);
    expire();

    phase = "R7"; now = 10000;
    tgt(30000); chk("R7 first", cmd_ticks, 1667); fin(1);
    tgt(29000); chk("R7 second", cmd_ticks, 1584); fin(1);
    tgt(28000); chk("R7 third", cmd_ticks, 1500); fin(1);
    tgt(27000); chk("R7 cap reached", cmd_req, 0);

    phase = "R10";
    @(negedge clk) begin expv = 1; tv = 1; tval = 26000; end
    @(negedge clk) begin expv = 0; tv = 0; end
    chk("R10 req", cmd_req, 1); chk("R10 ticks", cmd_ticks, 1334);

    phase = "R5";
    tgt(25000); chk("R5 recorded no req", cmd_req, 0);
    tgt(25500); chk("R5 later dropped", cmd_req, 0);
    fin(1);     chk("R5 not on done edge", cmd_req, 0);
    @(negedge clk);
    chk("R5 deferred req", cmd_req, 1); chk("R5 deferred ticks", cmd_ticks, 1250);

    phase = "R11";
    tgt(24000); chk("R11 recorded", cmd_req, 0);
    @(negedge clk) begin done = 1; ok = 1; end
    @(negedge clk) begin done = 0; ok = 0; tv = 1; tval = 23000; end
    @(negedge clk) tv = 0;
    chk("R11 req", cmd_req, 1); chk("R11 fresh target used", cmd_ticks, 1084);
    fin(1);
    expire();

    phase = "R8";
    tgt(20000); chk("R8 req", cmd_ticks, 834);
    fin(0);
    now = 1000000;
    repeat (3) @(negedge clk);
    chk("R8 failed done not running", timer_failed, 0);

    phase = "R9";
    tgt(1010000); chk("R9 req", cmd_req, 1); chk("R9 ticks", cmd_ticks, 834);
    fin(1);
    now = 1130008;
    repeat (2) @(negedge clk);
    chk("R9 at grace edge", timer_failed, 0);
    now = 1130009;
    @(negedge clk);
    chk("R9 stuck", timer_failed, 1);
    tgt(2000000); chk("R9 no req after fail", cmd_req, 0); chk("R9 sticky", timer_failed, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule